// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations for 32-bit addresses with 4 KB pages. The upper 20 bits of an address are the page number and the lower 12 bits are the offset. A lookup request compares its page number against every valid entry at once. The registered result appears in the next cycle. On a hit, the physical address is the stored frame number followed by the unchanged offset.

If no valid entry matches, the block raises a one-cycle miss-exception pulse. Software then walks the page table and installs the translation through the refill port. The block never reads the page table itself.

A refill whose page number is already present overwrites that entry. Otherwise the refill takes the lowest-numbered invalid slot. When every slot is valid, a round-robin victim pointer picks the slot to replace. A synchronous invalidate-all input empties the buffer.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is invalid, `lk_hit` and `lk_miss_exc` are 0, and any lookup misses.
- R2: One cycle after a lookup of a page held in a valid entry, `lk_hit` is 1 and `lk_paddr` equals {stored frame number, `lk_vaddr[11:0]`}.
- R3: One cycle after a lookup of a page held in no valid entry, `lk_miss_exc` is 1 and `lk_hit` is 0. The pulse lasts one cycle per request, and the two flags are never 1 together.
- R4: In the cycle after one with `lk_valid` low, both `lk_hit` and `lk_miss_exc` are 0.
- R5: A refill of a new page number, while any slot is invalid, goes to the lowest-numbered invalid slot. A buffer of ENTRIES slots therefore holds ENTRIES distinct pages without losing any.
- R6: A refill whose page number matches a valid entry rewrites that entry's frame number. It allocates no slot, evicts nothing and never creates a duplicate match.
- R7: A refill of a new page number into a full buffer replaces the slot at the victim pointer. The pointer starts at 0 after reset, advances by one only on such a replacement, and wraps from ENTRIES-1 to 0.
- R8: `flush_all` clears every valid bit at the clock edge. A refill in the same cycle is discarded, and later lookups miss until new refills arrive.
- R9: A lookup in the same cycle as a refill or flush sees the table as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag for the previous cycle's request |
| lk_miss_exc | output | 1 | One-cycle miss-exception pulse |
| lk_paddr | output | 32 | Physical address; meaningful only while `lk_hit` is 1 |
| wr_en | input | 1 | Refill strobe |
| wr_vpn | input | 20 | Page number to install |
| wr_pfn | input | 20 | Frame number to install |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with ENTRIES set to 4. Filling the buffer then takes four refills, so the move from free-slot allocation to round-robin replacement is reached in a few cycles. The bench checks the victim pointer stepping across two consecutive replacements. It also checks that rewriting an existing page spares the slot the pointer would otherwise have evicted. The default of 16 entries is covered by elaboration only.

// File: rtl/xb_pkg.sv
// Shared widths and types for the translation buffer.
// Assumes 32-bit virtual and physical addresses and 4 KB pages.
package xb_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int PN_W   = ADDR_W - OFF_W;

    typedef logic [PN_W-1:0]   pn_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/xb_match.sv
// Parallel comparator array: flags every valid entry whose page number
// equals the key. Assumes the table holds no duplicate valid page numbers,
// so at most one flag is set.
module xb_match
    import xb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][PN_W-1:0] ent_pn,
    input  pn_t                          key,
    output logic [ENTRIES-1:0]           match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // one comparator per entry, gated by its valid bit
        assign match[g] = ent_valid[g] && (ent_pn[g] == key);
    end
endmodule

// File: rtl/xb_slot_pick.sv
// Chooses the slot a refill writes: the entry that already holds the page,
// else the lowest invalid entry, else the victim pointer.
// Assumes wr_match has at most one bit set.
module xb_slot_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] wr_match,
    input  logic [IDX_W-1:0]   victim,
    output logic [IDX_W-1:0]   slot,
    output logic               replacing
);
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // encode the matching slot and the lowest free slot
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        any_free  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (wr_match[i]) match_idx = IDX_W'(i);
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // priority: existing page, then free slot, then victim
    always_comb begin
        replacing = 1'b0;
        if (|wr_match)     slot = match_idx;
        else if (any_free) slot = free_idx;
        else begin
            slot      = victim;
            replacing = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_buf.sv
// Fully associative translation buffer, top level. Holds ENTRIES page
// translations, answers a lookup one cycle after the request and pulses
// a miss exception when no entry matches. Refill and flush come from
// software. Assumes refills keep page numbers unique, which the slot
// picker guarantees.
module xlat_buf
    import xb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic        lk_miss_exc,
    output logic [31:0] lk_paddr,
    input  logic        wr_en,
    input  logic [19:0] wr_vpn,
    input  logic [19:0] wr_pfn,
    input  logic        flush_all
);
    logic [ENTRIES-1:0]           valid_q;
    logic [ENTRIES-1:0][PN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PN_W-1:0] pfn_q;
    logic [IDX_W-1:0]             victim_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [IDX_W-1:0]   wr_slot;
    logic               wr_replacing;
    pn_t                lk_pfn;

    xb_match #(.ENTRIES(ENTRIES)) u_lk_cmp (
        .ent_valid (valid_q),
        .ent_pn    (vpn_q),
        .key       (lk_vaddr[ADDR_W-1:OFF_W]),
        .match     (lk_match)
    );

    xb_match #(.ENTRIES(ENTRIES)) u_wr_cmp (
        .ent_valid (valid_q),
        .ent_pn    (vpn_q),
        .key       (wr_vpn),
        .match     (wr_match)
    );

    xb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
        .ent_valid (valid_q),
        .wr_match  (wr_match),
        .victim    (victim_q),
        .slot      (wr_slot),
        .replacing (wr_replacing)
    );

    // one-hot select of the matching frame number
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
    end

    // valid bits and victim pointer; flush takes priority over refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_slot] <= 1'b1;
            if (wr_replacing) begin
                victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
            end
        end
    end

    // page and frame storage, written on an accepted refill
    always_ff @(posedge clk) begin
        if (wr_en && !flush_all) begin
            vpn_q[wr_slot] <= wr_vpn;
            pfn_q[wr_slot] <= wr_pfn;
        end
    end

    // registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit      <= 1'b0;
            lk_miss_exc <= 1'b0;
            lk_paddr    <= '0;
        end else begin
            lk_hit      <= lk_valid && (|lk_match);
            lk_miss_exc <= lk_valid && !(|lk_match);
            lk_paddr    <= {lk_pfn, lk_vaddr[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/xlat_buf_chk.sv
// Property checker for xlat_buf, attached by bind. Observes the ports plus
// the valid vector and lookup match vector.
module xlat_buf_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [31:0]        lk_vaddr,
    input logic               lk_hit,
    input logic               lk_miss_exc,
    input logic [31:0]        lk_paddr,
    input logic               flush_all,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_match
);
    // R3: hit and miss are never raised together
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss_exc));

    // R3: every request gets exactly one answer in the next cycle
    a_r3_answer: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (lk_hit || lk_miss_exc));

    // R4: no request, no flags
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_miss_exc));

    // R2: offset passes through untouched on a hit
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || (lk_paddr[11:0] == $past(lk_vaddr[11:0]))));

    // R8: a flush leaves no valid entry
    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R6: no duplicate page can match a lookup
    a_r6_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind xlat_buf xlat_buf_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .lk_hit      (lk_hit),
    .lk_miss_exc (lk_miss_exc),
    .lk_paddr    (lk_paddr),
    .flush_all   (flush_all),
    .valid_q     (valid_q),
    .lk_match    (lk_match)
);

// File: tb/xlat_buf_bench.sv
// Directed bench for xlat_buf with four entries.
module xlat_buf_bench;
    localparam int CLK_P = 10;
    localparam int N     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss_exc;
    logic [31:0] lk_paddr;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_pfn = '0;
    logic        flush_all = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    xlat_buf #(.ENTRIES(N)) u_xlat_buf (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss_exc(lk_miss_exc), .lk_paddr(lk_paddr),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .flush_all(flush_all)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0; wr_en = 1'b0; flush_all = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn);
        wr_en = 1'b1; wr_vpn = vpn; wr_pfn = pfn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // lookup expecting a hit with the given physical address
    task automatic expect_hit(input logic [31:0] va, input logic [31:0] pa, input string req);
        lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        check(lk_hit === 1'b1 && lk_miss_exc === 1'b0, req, {30'b0, lk_hit, lk_miss_exc}, 32'h2);
        check(lk_paddr === pa, req, lk_paddr, pa);
    endtask

    // lookup expecting a miss pulse of exactly one cycle
    task automatic expect_miss(input logic [31:0] va, input string req);
        lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        check(lk_hit === 1'b0 && lk_miss_exc === 1'b1, req, {30'b0, lk_hit, lk_miss_exc}, 32'h1);
        @(negedge clk);
        check(lk_miss_exc === 1'b0 && lk_hit === 1'b0, {req, " R4 pulse end"},
              {30'b0, lk_hit, lk_miss_exc}, 32'h0);
    endtask

    task automatic t_reset();
        do_reset();
        check(lk_hit === 1'b0 && lk_miss_exc === 1'b0, "R1 reset flags",
              {30'b0, lk_hit, lk_miss_exc}, 32'h0);
        expect_miss(32'h1234_5678, "R1 empty lookup");
    endtask

    task automatic t_hit_miss();
        refill(20'h12345, 20'hABCDE);
        expect_hit(32'h1234_5678, 32'hABCD_E678, "R2 hit");
        expect_hit(32'h1234_5FFF, 32'hABCD_EFFF, "R2 offset");
        expect_miss(32'h2222_2000, "R3 miss");
        @(negedge clk);
        check(!lk_hit && !lk_miss_exc, "R4 idle", {30'b0, lk_hit, lk_miss_exc}, 32'h0);
    endtask

    task automatic t_fill_and_rewrite();
        do_reset();
        for (int i = 0; i < N; i++) refill(20'h00100 + 20'(i), 20'h00200 + 20'(i));
        for (int i = 0; i < N; i++)
            expect_hit({20'h00100 + 20'(i), 12'h0AB}, {20'h00200 + 20'(i), 12'h0AB}, "R5 fill");
        refill(20'h00102, 20'h00777);
        expect_hit(32'h0010_2004, 32'h0077_7004, "R6 rewrite");
        expect_hit(32'h0010_0004, 32'h0020_0004, "R6 no eviction");
    endtask

    task automatic t_victim();
        do_reset();
        for (int i = 0; i < N; i++) refill(20'h00100 + 20'(i), 20'h00200 + 20'(i));
        refill(20'h00300, 20'h00400);
        expect_miss(32'h0010_0000, "R7 slot0 evicted");
        expect_hit(32'h0030_0010, 32'h0040_0010, "R7 new entry");
        expect_hit(32'h0010_1010, 32'h0020_1010, "R7 slot1 kept");
        refill(20'h00301, 20'h00401);
        expect_miss(32'h0010_1000, "R7 slot1 evicted");
        expect_hit(32'h0010_2020, 32'h0020_2020, "R7 slot2 kept");
        expect_hit(32'h0030_1020, 32'h0040_1020, "R7 second new");
    endtask

    task automatic t_flush();
        // lookup in the flush cycle still sees the old table (R9)
        flush_all = 1'b1; lk_valid = 1'b1; lk_vaddr = 32'h0030_0001;
        @(negedge clk);
        flush_all = 1'b0; lk_valid = 1'b0;
        check(lk_hit === 1'b1 && lk_paddr === 32'h0040_0001, "R9 lookup during flush",
              lk_paddr, 32'h0040_0001);
        expect_miss(32'h0030_0000, "R8 flushed");
        expect_miss(32'h0010_3000, "R8 flushed other");
        flush_all = 1'b1; wr_en = 1'b1; wr_vpn = 20'h00555; wr_pfn = 20'h00666;
        @(negedge clk);
        flush_all = 1'b0; wr_en = 1'b0;
        expect_miss(32'h0055_5000, "R8 refill dropped");
        // lookup in the refill cycle misses, the next one hits (R9)
        wr_en = 1'b1; wr_vpn = 20'h00555; wr_pfn = 20'h00666;
        lk_valid = 1'b1; lk_vaddr = 32'h0055_5000;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check(lk_miss_exc === 1'b1, "R9 lookup during refill", {31'b0, lk_miss_exc}, 32'h1);
        expect_hit(32'h0055_5ABC, 32'h0066_6ABC, "R8 refill after flush");
    endtask

    initial begin
        t_reset();
        t_hit_miss();
        t_fill_and_rewrite();
        t_victim();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule